// File: doc/BRIEF.md
# Compacting Instruction Queue

This block is an eight-slot holding queue for 32-bit instruction words that sits between an instruction cache and a dispatcher. The cache side writes a group of words, up to a full line, in one cycle. The dispatcher looks only at the four lowest slots. In one cycle it can take out any subset of those four. The remaining valid words then close the gaps and slide toward slot 0 without changing their program order. The four upper slots act only as buffering, so the cache is visited less often.

The dispatcher can also change an entry without removing it. It can turn a slot into a no-op bubble, which keeps its place in the order and moves down with the queue like any other entry. It can also tag a slot as already handed to the floating-point unit. A tagged entry stays queued until a later removal consumes it. The queue reports when all eight slots are occupied, and the fetch side must not request words while that indication is high.

Top module: `compact_iq`

## Requirements
- R1: A synchronous reset clears every valid bit and every floating-point tag. After reset, `full` is low and `freeCount` reads 8.
- R2: An accepted group of `wrCount` words is stored in the lowest free slots. Word k of the group is taken from `wrData[k*32 +: 32]` and lands one slot above word k-1, so word 0 takes the lowest slot.
- R3: `wrAccept` is high only when `wrValid` is high and `wrCount` does not exceed the free slots left after this cycle's removals. A group that is not accepted leaves the queue contents unchanged.
- R4: Bit i of `rmMask` (i = 0..3) removes slot Qi. At the same clock edge the remaining valid entries move down to slot 0 upward, in their original order.
- R5: A mask bit that points at an empty slot has no effect.
- R6: Slots freed by removals in a cycle can be used by a group written in that same cycle. The new words are placed above the compacted survivors.
- R7: With `bubbleEn`, the valid slot at `bubbleIdx` (0..3) stays valid but its word becomes the `NOP_WORD` parameter, 32'h60000000 by default. Its tag is cleared. The bubble keeps its relative order as the queue compacts.
- R8: With `markEn`, the valid slot at `markIdx` (0..3) gets its tag set in `slotFpu`. The entry stays queued, and its tag travels with it as it moves down.
- R9: `full` is high exactly when all eight slots are valid, and `freeCount` equals 8 minus the number of valid slots.
- R10: When a slot is both removed and targeted by a bubble or tag request in the same cycle, the removal wins and the slot's content is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rmMask | input | 4 | Removal mask over Q0..Q3 |
| bubbleEn | input | 1 | Replace one low slot with a bubble |
| bubbleIdx | input | 2 | Slot targeted by the bubble request |
| markEn | input | 1 | Set the floating-point tag on one low slot |
| markIdx | input | 2 | Slot targeted by the tag request |
| wrValid | input | 1 | A word group is offered |
| wrCount | input | 4 | Number of words in the group, 0..8 |
| wrData | input | 256 | Word group, word k at bits k*32 upward |
| wrAccept | output | 1 | The offered group is taken this cycle |
| slotWords | output | 256 | Slot words, Qi at bits i*32 upward |
| slotValid | output | 8 | Per-slot valid bits |
| slotFpu | output | 8 | Per-slot floating-point tags |
| full | output | 1 | All slots occupied |
| freeCount | output | 4 | Number of empty slots |

## Verification
Compaction is tried with scattered masks such as Q0 and Q2 together, with a mask that only partly covers the valid entries, and with a mask that points at empty slots. These cases separate an order-preserving shift from a plain shift by the number of removals. Writes are offered into an empty queue, into a partly filled queue, one word beyond the free space, and together with removals. These cases show whether placement uses the count after compaction. Bubbles and tags are placed above a removed entry, so that they must move down with their words. They are also placed on the slot being removed, which shows that removal takes precedence.

// File: rtl/ciq_pkg.sv
package ciq_pkg;
  parameter int IQ_DEPTH = 8;
  parameter int IQ_WIN   = 4;
  parameter int IQ_WORD  = 32;
  localparam int IQ_CW   = $clog2(IQ_DEPTH + 1);
  localparam int IQ_IW   = $clog2(IQ_WIN);

  typedef struct packed {
    logic [IQ_DEPTH-1:0] keep;       // entries surviving this cycle
    logic [IQ_DEPTH-1:0] bubbleHot;  // entry to overwrite with a bubble
    logic [IQ_DEPTH-1:0] markHot;    // entry to tag as sent to the FPU
    logic [IQ_CW-1:0]    keptCount;  // survivors after compaction
    logic                wrEn;       // append the incoming group
    logic [IQ_CW-1:0]    wrCount;
  } ciq_strobe_t;
endpackage

// File: rtl/ciq_ctrl.sv
module ciq_ctrl
  import ciq_pkg::*;
(
  input  logic [IQ_DEPTH-1:0] slotValid,
  input  logic [IQ_WIN-1:0]   rmMask,
  input  logic                bubbleEn,
  input  logic [IQ_IW-1:0]    bubbleIdx,
  input  logic                markEn,
  input  logic [IQ_IW-1:0]    markIdx,
  input  logic                wrValid,
  input  logic [IQ_CW-1:0]    wrCount,
  output ciq_strobe_t         strobes,
  output logic                wrAccept,
  output logic                full,
  output logic [IQ_CW-1:0]    freeCount
);
  logic [IQ_DEPTH-1:0] rmWide;
  logic [IQ_DEPTH-1:0] keepMask;
  logic [IQ_CW-1:0]    keptCnt;
  logic [IQ_CW-1:0]    validCnt;
  logic [IQ_CW-1:0]    freeAfter;
  logic                acceptInt;

  assign rmWide   = IQ_DEPTH'(rmMask);
  assign keepMask = slotValid & ~rmWide;

  always_comb begin
    keptCnt  = '0;
    validCnt = '0;
    for (int i = 0; i < IQ_DEPTH; i++) begin
      keptCnt  = keptCnt + IQ_CW'(keepMask[i]);
      validCnt = validCnt + IQ_CW'(slotValid[i]);
    end
  end

  assign freeAfter = IQ_CW'(IQ_DEPTH) - keptCnt;
  assign acceptInt = wrValid && (wrCount <= freeAfter);

  always_comb begin
    strobes           = '0;
    strobes.keep      = keepMask;
    strobes.keptCount = keptCnt;
    strobes.wrEn      = acceptInt;
    strobes.wrCount   = wrCount;
    if (bubbleEn) strobes.bubbleHot[bubbleIdx] = 1'b1;
    if (markEn)   strobes.markHot[markIdx]     = 1'b1;
    strobes.bubbleHot = strobes.bubbleHot & keepMask;
    strobes.markHot   = strobes.markHot & keepMask;
  end

  assign wrAccept  = acceptInt;
  assign full      = (validCnt == IQ_CW'(IQ_DEPTH));
  assign freeCount = IQ_CW'(IQ_DEPTH) - validCnt;
endmodule

// File: rtl/ciq_data.sv
module ciq_data
  import ciq_pkg::*;
#(
  parameter logic [IQ_WORD-1:0] NOP_WORD = 32'h6000_0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ciq_strobe_t                 strobes,
  input  logic [IQ_DEPTH*IQ_WORD-1:0] wrData,
  output logic [IQ_DEPTH*IQ_WORD-1:0] slotWords,
  output logic [IQ_DEPTH-1:0]         slotValid,
  output logic [IQ_DEPTH-1:0]         slotFpu
);
  logic [IQ_WORD-1:0]  curWord [IQ_DEPTH];
  logic [IQ_WORD-1:0]  nxtWord [IQ_DEPTH];
  logic [IQ_DEPTH-1:0] curVal, nxtVal, curFpu, nxtFpu;

  always_comb begin
    int dest;
    int kept;
    int cnt;
    dest = 0;
    kept = int'(strobes.keptCount);
    cnt  = int'(strobes.wrCount);
    nxtVal = '0;
    nxtFpu = '0;
    for (int j = 0; j < IQ_DEPTH; j++) nxtWord[j] = curWord[j];
    // close gaps: each survivor goes to the slot given by its rank
    for (int i = 0; i < IQ_DEPTH; i++) begin
      if (strobes.keep[i]) begin
        nxtVal[dest]  = 1'b1;
        nxtWord[dest] = strobes.bubbleHot[i] ? NOP_WORD : curWord[i];
        nxtFpu[dest]  = (curFpu[i] && !strobes.bubbleHot[i]) || strobes.markHot[i];
        dest = dest + 1;
      end
    end
    // append the incoming group above the survivors
    if (strobes.wrEn) begin
      for (int j = 0; j < IQ_DEPTH; j++) begin
        if (j >= kept && j < kept + cnt) begin
          nxtVal[j]  = 1'b1;
          nxtFpu[j]  = 1'b0;
          nxtWord[j] = wrData[(j - kept)*IQ_WORD +: IQ_WORD];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curVal <= '0;
      curFpu <= '0;
    end else begin
      curVal <= nxtVal;
      curFpu <= nxtFpu;
    end
    for (int j = 0; j < IQ_DEPTH; j++) curWord[j] <= nxtWord[j];
  end

  for (genvar g = 0; g < IQ_DEPTH; g++) begin : gOut
    assign slotWords[g*IQ_WORD +: IQ_WORD] = curWord[g];
  end
  assign slotValid = curVal;
  assign slotFpu   = curFpu;
endmodule

// File: rtl/compact_iq.sv
module compact_iq
  import ciq_pkg::*;
#(
  parameter logic [IQ_WORD-1:0] NOP_WORD = 32'h6000_0000
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IQ_WIN-1:0]           rmMask,
  input  logic                        bubbleEn,
  input  logic [IQ_IW-1:0]            bubbleIdx,
  input  logic                        markEn,
  input  logic [IQ_IW-1:0]            markIdx,
  input  logic                        wrValid,
  input  logic [IQ_CW-1:0]            wrCount,
  input  logic [IQ_DEPTH*IQ_WORD-1:0] wrData,
  output logic                        wrAccept,
  output logic [IQ_DEPTH*IQ_WORD-1:0] slotWords,
  output logic [IQ_DEPTH-1:0]         slotValid,
  output logic [IQ_DEPTH-1:0]         slotFpu,
  output logic                        full,
  output logic [IQ_CW-1:0]            freeCount
);
  ciq_strobe_t strobes;

  ciq_ctrl uCtrl (
    .slotValid (slotValid),
    .rmMask    (rmMask),
    .bubbleEn  (bubbleEn),
    .bubbleIdx (bubbleIdx),
    .markEn    (markEn),
    .markIdx   (markIdx),
    .wrValid   (wrValid),
    .wrCount   (wrCount),
    .strobes   (strobes),
    .wrAccept  (wrAccept),
    .full      (full),
    .freeCount (freeCount)
  );

  ciq_data #(.NOP_WORD(NOP_WORD)) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wrData    (wrData),
    .slotWords (slotWords),
    .slotValid (slotValid),
    .slotFpu   (slotFpu)
  );
endmodule

// File: rtl/compact_iq_checker.sv
module compact_iq_checker
  import ciq_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [IQ_WIN-1:0]   rmMask,
  input logic                bubbleEn,
  input logic                markEn,
  input logic                wrValid,
  input logic                wrAccept,
  input logic [IQ_CW-1:0]    wrCount,
  input logic [IQ_DEPTH-1:0] slotValid,
  input logic [IQ_DEPTH-1:0] slotFpu,
  input logic                full,
  input logic [IQ_CW-1:0]    freeCount
);
  AST_VALID_PACKED: assert property (@(posedge clk) disable iff (rst)
    ((slotValid & (slotValid + 1'b1)) == '0)); // R4

  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
    full == (slotValid == '1)); // R9

  AST_FREE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (int'(freeCount) + $countones(slotValid)) == IQ_DEPTH); // R9

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wrValid && !wrAccept && rmMask == '0 && !bubbleEn && !markEn)
      |=> $stable(slotValid) && $stable(slotFpu)); // R3

  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (rst)
    (wrAccept && rmMask == '0)
      |=> $countones(slotValid) == $countones($past(slotValid)) + int'($past(wrCount))); // R2

  AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    ((slotFpu & ~slotValid) == '0)); // R8
endmodule

bind compact_iq compact_iq_checker uChk (
  .clk       (clk),
  .rst       (rst),
  .rmMask    (rmMask),
  .bubbleEn  (bubbleEn),
  .markEn    (markEn),
  .wrValid   (wrValid),
  .wrAccept  (wrAccept),
  .wrCount   (wrCount),
  .slotValid (slotValid),
  .slotFpu   (slotFpu),
  .full      (full),
  .freeCount (freeCount)
);

// File: tb/compact_iq_test.sv
module compact_iq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WW = 32;
  localparam logic [WW-1:0] NOP = 32'h6000_0000;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [3:0]            rmMask = '0;
  logic                  bubbleEn = 1'b0;
  logic [1:0]            bubbleIdx = '0;
  logic                  markEn = 1'b0;
  logic [1:0]            markIdx = '0;
  logic                  wrValid = 1'b0;
  logic [3:0]            wrCount = '0;
  logic [DEPTH*WW-1:0]   wrData = '0;
  logic                  wrAccept;
  logic [DEPTH*WW-1:0]   slotWords;
  logic [DEPTH-1:0]      slotValid;
  logic [DEPTH-1:0]      slotFpu;
  logic                  full;
  logic [3:0]            freeCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model of the queue contents
  logic [WW-1:0] mWord [DEPTH];
  bit            mFpu  [DEPTH];
  int            mCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  compact_iq uut (
    .clk(clk), .rst(rst), .rmMask(rmMask), .bubbleEn(bubbleEn),
    .bubbleIdx(bubbleIdx), .markEn(markEn), .markIdx(markIdx),
    .wrValid(wrValid), .wrCount(wrCount), .wrData(wrData),
    .wrAccept(wrAccept), .slotWords(slotWords), .slotValid(slotValid),
    .slotFpu(slotFpu), .full(full), .freeCount(freeCount)
  );

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    logic [DEPTH-1:0] ev, ef;
    int wrong = 0;
    ev = '0; ef = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < mCnt) begin
        ev[i] = 1'b1;
        ef[i] = mFpu[i];
        if (slotWords[i*WW +: WW] != mWord[i]) begin
          wrong++;
          $display("FAIL %s word Q%0d actual=%0h expected=%0h", req, i,
                   slotWords[i*WW +: WW], mWord[i]);
        end
      end
    end
    total++;
    if (wrong != 0) bad++;
    check(req, "valid", slotValid, ev);
    check(req, "tags", slotFpu, ef);
    check("R9", "full", full, mCnt == DEPTH);
    check("R9", "freeCount", freeCount, DEPTH - mCnt);
  endtask

  // one cycle of stimulus; the model follows the requirements
  task automatic step(string req, logic [3:0] mask, bit bEn, int bIdx,
                      bit kEn, int kIdx, bit wv, int n, logic [WW-1:0] base);
    logic [WW-1:0] nw [DEPTH];
    bit nf [DEPTH];
    int k = 0;
    bit expAcc;
    @(negedge clk);
    rmMask = mask; bubbleEn = bEn; bubbleIdx = 2'(bIdx);
    markEn = kEn; markIdx = 2'(kIdx);
    wrValid = wv; wrCount = 4'(n);
    for (int j = 0; j < DEPTH; j++) wrData[j*WW +: WW] = base + WW'(j);
    for (int i = 0; i < mCnt; i++) begin
      if (!(i < 4 && mask[i])) begin
        nw[k] = mWord[i];
        nf[k] = mFpu[i];
        if (bEn && i == bIdx) begin nw[k] = NOP; nf[k] = 0; end
        if (kEn && i == kIdx) nf[k] = 1;
        k++;
      end
    end
    expAcc = wv && (n <= DEPTH - k);
    #1;
    check(expAcc ? "R6" : "R3", "wrAccept", wrAccept, expAcc);
    if (expAcc) for (int j = 0; j < n; j++) begin
      nw[k] = base + WW'(j); nf[k] = 0; k++;
    end
    for (int i = 0; i < k; i++) begin mWord[i] = nw[i]; mFpu[i] = nf[i]; end
    mCnt = k;
    @(posedge clk);
    #2;
    rmMask = '0; bubbleEn = 0; markEn = 0; wrValid = 0; wrCount = '0;
    compareAll(req);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    mCnt = 0;
    compareAll("R1");
  endtask

  task automatic testFill();
    step("R2", 4'b0000, 0, 0, 0, 0, 1, 3, 32'h100);
    step("R2", 4'b0000, 0, 0, 0, 0, 1, 5, 32'h200);
    step("R9", 4'b0000, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R3", 4'b0000, 0, 0, 0, 0, 1, 1, 32'h300);
  endtask

  task automatic testCompact();
    step("R4", 4'b0101, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R4", 4'b1010, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R3", 4'b0000, 0, 0, 0, 0, 1, 5, 32'h400);
  endtask

  task automatic testRemoveAndWrite();
    step("R6", 4'b0000, 0, 0, 0, 0, 1, 4, 32'h500);
    step("R6", 4'b0011, 0, 0, 0, 0, 1, 2, 32'h600);
    step("R6", 4'b1001, 0, 0, 0, 0, 1, 3, 32'h700);
  endtask

  task automatic testEmptyMask();
    testReset();
    step("R2", 4'b0000, 0, 0, 0, 0, 1, 2, 32'h800);
    step("R5", 4'b1110, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R5", 4'b1110, 0, 0, 0, 0, 0, 0, 32'h0);
  endtask

  task automatic testBubbleTag();
    testReset();
    step("R2", 4'b0000, 0, 0, 0, 0, 1, 6, 32'h900);
    step("R7", 4'b0000, 1, 2, 0, 0, 0, 0, 32'h0);
    step("R7", 4'b0001, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R8", 4'b0000, 0, 0, 1, 3, 0, 0, 32'h0);
    step("R8", 4'b0011, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R8", 4'b0001, 0, 0, 0, 0, 0, 0, 32'h0);
    step("R10", 4'b0010, 1, 1, 1, 1, 0, 0, 32'h0);
    step("R10", 4'b0001, 0, 0, 1, 0, 1, 3, 32'hA00);
  endtask

  initial begin
    testReset();
    testFill();
    testCompact();
    testRemoveAndWrite();
    testEmptyMask();
    testBubbleTag();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule